// File: doc/BRIEF.md
# Prime-Length DCT Operand Preparation Stage

This block sits in front of a linear convolution array that computes a prime-length discrete cosine transform. It takes one block of N real samples, delivered serially with the highest index first. A running subtractor turns them into a backward difference sequence. The differences at indices 1..N-1 are then reordered along the powers of a primitive root modulo N. Each value in the first half of the reordered list is folded with its partner in the second half into a sum and a difference. The value at index 0 is passed to the array unchanged alongside every pair.

Samples shift through a serial register chain. When the last sample of a block arrives, the whole set moves in one step into a holding bank in permuted order. The next block can therefore stream in on the following cycle while the previous one drains as (N-1)/2 operand pairs, one pair per cycle. The defaults are N = 7 with primitive root 3, and 12-bit signed samples.

Top module: `dctprep_top`

## Requirements
- R1: While reset is high, and on every cycle after reset until a block completes, `out_valid` is 0.
- R2: Samples arrive index N-1 first. The sample with `in_first`=1 is y(N-1). The difference sequence is d(N-1)=y(N-1) and d(i)=y(i)-d(i+1) for i=N-2 down to 0. `out_x0` carries d(0).
- R3: The reordered sequence is p(i)=d(3^i mod 7) for i=1..6, so p(1..6) = d(3), d(2), d(6), d(4), d(5), d(1).
- R4: For pair index k=1..3, the outputs are `out_sum`=p(k)+p(k+3), `out_diff`=p(k)-p(k+3) and `out_idx`=k. `out_x0` holds the same value for all three pairs of a block.
- R5: If the index-0 sample of a block is accepted at clock edge E, then pair k is valid after edge E+k. The three pairs come on consecutive cycles in the order k=1,2,3, and `out_first` is 1 only with k=1.
- R6: A new block may start on the cycle right after the previous block's last sample. Both blocks produce correct pairs and neither is delayed.
- R7: Cycles with `in_valid`=0 inside a block are ignored. The result equals that of the same samples sent without gaps.
- R8: A sample with `in_valid`=1 and `in_first`=0 that arrives when no block is open is ignored and produces no output.
- R9: `in_first`=1 in the middle of a block discards the partial block. Only the restarted block produces pairs.
- R10: Differences are W+3 bits and pairs W+4 bits wide. Full-scale alternating inputs produce exact, unwrapped results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_first | input | 1 | Marks y(N-1), the first sample of a block |
| in_sample | input | W | Signed sample |
| out_valid | output | 1 | Pair strobe |
| out_first | output | 1 | First pair of a block |
| out_idx | output | clog2((N-1)/2+1) | Pair index k, starting at 1 |
| out_x0 | output | W+clog2(N) | d(0) of the block |
| out_sum | output | W+clog2(N)+1 | p(k)+p(k+H) |
| out_diff | output | W+clog2(N)+1 | p(k)-p(k+H) |

## Verification
Distinct non-symmetric sample sets expose a reversed recursion sign or a wrong permutation. Either fault swaps or negates sums and differences. Back-to-back blocks catch a holding bank that is overwritten while the previous block is still draining. Gapped blocks catch a difference register that updates on idle cycles. Stray unmarked samples and mid-block restarts check that a broken block-open flag does not emit spurious or doubled bursts. Full-scale alternating input catches a datapath one guard bit short, which would wrap the sign of d(0) and of the pairs.

// File: rtl/dctprep_pkg.sv
package dctprep_pkg;

    // Block fill phase of the difference stage
    typedef enum logic {
        BLK_IDLE = 1'b0,
        BLK_FILL = 1'b1
    } blk_state_e;

    // g^e mod n, evaluated at elaboration for the reorder map
    function automatic int pow_mod(input int g, input int e, input int n);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) begin
            r = (r * g) % n;
        end
        return r;
    endfunction

    // Extra bits so an N-term alternating sum cannot wrap
    function automatic int guard_bits(input int n);
        return $clog2(n);
    endfunction

endpackage

// File: rtl/dctprep_recur.sv
module dctprep_recur
    import dctprep_pkg::*;
#(
    parameter int W  = 12,
    parameter int N  = 7,
    parameter int XW = W + 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_first,
    input  logic [W-1:0]           in_sample,
    output logic                   blk_done,
    output logic [N-1:0][XW-1:0]   x_vec
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] START_CNT = IW'(N - 2);

    blk_state_e               state;
    logic [IW-1:0]            cnt;
    logic signed [XW-1:0]     acc;
    logic signed [XW-1:0]     y_ext;
    logic signed [XW-1:0]     x_now;
    logic                     accept;
    logic [N-2:0][XW-1:0]     chain;

    assign y_ext    = {{(XW-W){in_sample[W-1]}}, in_sample};
    assign x_now    = in_first ? y_ext : (y_ext - acc);
    assign accept   = in_valid && (in_first || (state == BLK_FILL));
    assign blk_done = in_valid && !in_first && (state == BLK_FILL) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BLK_IDLE;
            cnt   <= '0;
            acc   <= '0;
        end else if (accept) begin
            acc <= x_now;
            if (in_first) begin
                state <= BLK_FILL;
                cnt   <= START_CNT;
            end else if (cnt == '0) begin
                state <= BLK_IDLE;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Serial chain: newest difference enters at slot 0
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (accept) begin
            chain <= {chain[N-3:0], x_now};
        end
    end

    // On the closing sample, d(j) sits in chain[j-1] and d(0) is x_now
    assign x_vec[0] = x_now;
    for (genvar j = 1; j < N; j++) begin : g_xvec
        assign x_vec[j] = chain[j-1];
    end

endmodule

// File: rtl/dctprep_permlatch.sv
module dctprep_permlatch
    import dctprep_pkg::*;
#(
    parameter int N  = 7,
    parameter int G  = 3,
    parameter int XW = 15
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [N-1:0][XW-1:0]   x_vec,
    output logic [XW-1:0]          hold_x0,
    output logic [N-2:0][XW-1:0]   hold_perm
);
    logic [N-2:0][XW-1:0] perm_next;

    // Fixed wiring: slot i-1 receives d(G^i mod N)
    for (genvar i = 1; i < N; i++) begin : g_map
        localparam int SRC = pow_mod(G, i, N);
        assign perm_next[i-1] = x_vec[SRC];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_x0   <= '0;
            hold_perm <= '0;
        end else if (load) begin
            hold_x0   <= x_vec[0];
            hold_perm <= perm_next;
        end
    end

endmodule

// File: rtl/dctprep_pairgen.sv
module dctprep_pairgen #(
    parameter int N  = 7,
    parameter int XW = 15
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  start,
    input  logic [XW-1:0]                         hold_x0,
    input  logic [N-2:0][XW-1:0]                  hold_perm,
    output logic                                  out_valid,
    output logic                                  out_first,
    output logic [$clog2((N-1)/2+1)-1:0]          out_idx,
    output logic [XW-1:0]                         out_x0,
    output logic [XW:0]                           out_sum,
    output logic [XW:0]                           out_diff
);
    localparam int H  = (N - 1) / 2;
    localparam int KW = $clog2(H + 1);
    localparam logic [KW-1:0] K_LAST = KW'(H - 1);

    logic              active;
    logic [KW-1:0]     k;
    logic signed [XW:0] lo_op;
    logic signed [XW:0] hi_op;

    always_comb begin
        lo_op = {hold_perm[int'(k)][XW-1],     hold_perm[int'(k)]};
        hi_op = {hold_perm[int'(k) + H][XW-1], hold_perm[int'(k) + H]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            k         <= '0;
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_idx   <= '0;
            out_x0    <= '0;
            out_sum   <= '0;
            out_diff  <= '0;
        end else begin
            out_valid <= active;
            if (active) begin
                out_first <= (k == '0);
                out_idx   <= k + 1'b1;
                out_x0    <= hold_x0;
                out_sum   <= lo_op + hi_op;
                out_diff  <= lo_op - hi_op;
                if (k == K_LAST) begin
                    active <= 1'b0;
                    k      <= '0;
                end else begin
                    k <= k + 1'b1;
                end
            end
            if (start) begin
                active <= 1'b1;
                k      <= '0;
            end
        end
    end

endmodule

// File: rtl/dctprep_top.sv
module dctprep_top
    import dctprep_pkg::*;
#(
    parameter int W = 12,
    parameter int N = 7,
    parameter int G = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic                                  in_first,
    input  logic [W-1:0]                          in_sample,
    output logic                                  out_valid,
    output logic                                  out_first,
    output logic [$clog2((N-1)/2+1)-1:0]          out_idx,
    output logic [W+$clog2(N)-1:0]                out_x0,
    output logic [W+$clog2(N):0]                  out_sum,
    output logic [W+$clog2(N):0]                  out_diff
);
    localparam int XW = W + guard_bits(N);

    logic                   blk_done;
    logic [N-1:0][XW-1:0]   x_vec;
    logic [XW-1:0]          hold_x0;
    logic [N-2:0][XW-1:0]   hold_perm;

    dctprep_recur #(.W(W), .N(N), .XW(XW)) u_recur (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_sample (in_sample),
        .blk_done  (blk_done),
        .x_vec     (x_vec)
    );

    dctprep_permlatch #(.N(N), .G(G), .XW(XW)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (blk_done),
        .x_vec     (x_vec),
        .hold_x0   (hold_x0),
        .hold_perm (hold_perm)
    );

    dctprep_pairgen #(.N(N), .XW(XW)) u_pairs (
        .clk       (clk),
        .rst       (rst),
        .start     (blk_done),
        .hold_x0   (hold_x0),
        .hold_perm (hold_perm),
        .out_valid (out_valid),
        .out_first (out_first),
        .out_idx   (out_idx),
        .out_x0    (out_x0),
        .out_sum   (out_sum),
        .out_diff  (out_diff)
    );

endmodule

// File: rtl/dctprep_chk.sv
module dctprep_chk #(
    parameter int W = 12,
    parameter int N = 7
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  out_valid,
    input logic                                  out_first,
    input logic [$clog2((N-1)/2+1)-1:0]          out_idx,
    input logic [W+$clog2(N)-1:0]                out_x0,
    input logic [W+$clog2(N):0]                  out_sum,
    input logic [W+$clog2(N):0]                  out_diff
);
    localparam int H = (N - 1) / 2;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R1

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_idx) >= 1 && int'(out_idx) <= H)); // R4

    AST_FIRST_IS_ONE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_first == (int'(out_idx) == 1))); // R5

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && int'(out_idx) < H) |=>
            (out_valid && out_idx == $past(out_idx) + 1'b1)); // R5

    AST_X0_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_first) |-> $stable(out_x0)); // R4

    AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sum[0] == out_diff[0])); // R4

endmodule

bind dctprep_top dctprep_chk #(.W(W), .N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_idx   (out_idx),
    .out_x0    (out_x0),
    .out_sum   (out_sum),
    .out_diff  (out_diff)
);

// File: tb/dctprep_top_test.sv
module dctprep_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 12;
    localparam int N  = 7;
    localparam int XW = W + 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_first = 1'b0;
    logic [W-1:0]         in_sample = '0;
    logic                 out_valid;
    logic                 out_first;
    logic [1:0]           out_idx;
    logic signed [XW-1:0] out_x0;
    logic signed [XW:0]   out_sum;
    logic signed [XW:0]   out_diff;

    int total = 0;
    int failed = 0;
    int cyc = 0;
    int last_acc = 0;
    bit done_flag = 1'b0;

    int ncap = 0;
    int cap_idx[64];
    int cap_first[64];
    int cap_x0[64];
    int cap_sum[64];
    int cap_diff[64];
    int cap_cyc[64];

    // Reordering stated in R3: p(1..6) = d(3), d(2), d(6), d(4), d(5), d(1)
    int perm_src[6] = '{3, 2, 6, 4, 5, 1};

    dctprep_top #(.W(W), .N(N), .G(3)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_first (out_first),
        .out_idx   (out_idx),
        .out_x0    (out_x0),
        .out_sum   (out_sum),
        .out_diff  (out_diff)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid && ncap < 64) begin
            cap_idx[ncap]   = int'(out_idx);
            cap_first[ncap] = int'(out_first);
            cap_x0[ncap]    = int'(out_x0);
            cap_sum[ncap]   = int'(out_sum);
            cap_diff[ncap]  = int'(out_diff);
            cap_cyc[ncap]   = cyc;
            ncap++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    task automatic put(input bit first, input int v);
        in_valid  = 1'b1;
        in_first  = first;
        in_sample = v[W-1:0];
        @(negedge clk);
        last_acc = cyc;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_first = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_block(input int y[7], input bit gaps, output int acc_at);
        for (int j = 6; j >= 0; j--) begin
            put(j == 6, y[j]);
            if (gaps && (j == 4 || j == 2)) idle(2);
        end
        acc_at = last_acc;
    endtask

    task automatic check_block(input string tag, input int y[7], input int base, input int acc_at);
        int d[7];
        int p[7];
        d[6] = y[6];
        for (int i = 5; i >= 0; i--) d[i] = y[i] - d[i+1];
        for (int i = 1; i <= 6; i++) p[i] = d[perm_src[i-1]];
        chk({tag, " R5 burst present"}, int'(ncap >= base + 3), 1);
        for (int k = 0; k < 3; k++) begin
            chk({tag, " R3 R4 sum"},  cap_sum[base+k],  p[k+1] + p[k+4]);
            chk({tag, " R3 R4 diff"}, cap_diff[base+k], p[k+1] - p[k+4]);
            chk({tag, " R2 x0"},      cap_x0[base+k],   d[0]);
            chk({tag, " R4 idx"},     cap_idx[base+k],  k + 1);
            chk({tag, " R5 first"},   cap_first[base+k], int'(k == 0));
            chk({tag, " R5 timing"},  cap_cyc[base+k],  acc_at + 1 + k);
        end
    endtask

    task automatic t_reset();
        chk("R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        idle(10);
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 no captures", ncap, 0);
    endtask

    task automatic t_basic();
        int a;
        int y1[7] = '{5, -3, 17, 2, -40, 9, 11};
        int y2[7] = '{-100, 250, 7, -9, 33, 1, -64};
        int b = ncap;
        send_block(y1, 1'b0, a);
        idle(6);
        check_block("basic1", y1, b, a);
        b = ncap;
        send_block(y2, 1'b0, a);
        idle(6);
        check_block("basic2", y2, b, a);
    endtask

    task automatic t_back_to_back();
        int a1;
        int a2;
        int ya[7] = '{1, 2, 3, 4, 5, 6, 7};
        int yb[7] = '{-7, 13, -21, 34, -55, 89, -144};
        int b = ncap;
        send_block(ya, 1'b0, a1);
        send_block(yb, 1'b0, a2);
        idle(6);
        check_block("R6 blockA", ya, b, a1);
        check_block("R6 blockB", yb, b + 3, a2);
        chk("R6 burst count", ncap - b, 6);
    endtask

    task automatic t_gaps();
        int a;
        int y[7] = '{300, -2, 45, 8, -77, 120, 3};
        int b = ncap;
        send_block(y, 1'b1, a);
        idle(6);
        check_block("R7 gapped", y, b, a);
    endtask

    task automatic t_stray();
        int a;
        int y[7] = '{9, 8, 7, -6, 5, 4, -3};
        int b = ncap;
        idle(2);
        put(1'b0, 500);
        put(1'b0, -500);
        put(1'b0, 123);
        idle(8);
        chk("R8 stray ignored", ncap - b, 0);
        send_block(y, 1'b0, a);
        idle(6);
        check_block("R8 after stray", y, b, a);
    endtask

    task automatic t_restart();
        int a;
        int y[7] = '{60, -61, 62, -63, 64, -65, 66};
        int b = ncap;
        put(1'b1, 999);
        put(1'b0, -888);
        put(1'b0, 777);
        put(1'b0, 12);
        send_block(y, 1'b0, a);
        idle(6);
        chk("R9 single burst", ncap - b, 3);
        check_block("R9 restarted", y, b, a);
    endtask

    task automatic t_extremes();
        int a;
        int y[7] = '{2047, -2048, 2047, -2048, 2047, -2048, 2047};
        int z[7] = '{-2048, 2047, -2048, 2047, -2048, 2047, -2048};
        int b = ncap;
        send_block(y, 1'b0, a);
        idle(6);
        check_block("R10 max", y, b, a);
        b = ncap;
        send_block(z, 1'b0, a);
        idle(6);
        check_block("R10 min", z, b, a);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        failed++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        idle(4);
        t_reset();
        t_basic();
        t_back_to_back();
        t_gaps();
        t_stray();
        t_restart();
        t_extremes();
        idle(4);
        summary();
    end

endmodule